// File: doc/BRIEF.md
# Ping-Pong Averaging Control and Status Registers

This block is the register bank of a ping-pong averaging engine. A host reaches it through a plain handshake port with independent write and read channels. Each channel carries an address, an enable, a ready flag and an error flag. The write channel also carries data, and the read channel returns data with a valid flag. The bank holds the settings the engine needs and drives them out continuously:

- an enable bit and a two-bit operating mode;
- ten 16-bit averaging weights;
- a two-bit input-masking mode and a two-bit input timeout.

The bank also reports the engine's progress as read-only status. One counter counts finished input-packet parses and a second counter counts finished output-packet builds. Both completion pulses come from a faster streaming clock. Each pulse becomes a toggle in the streaming domain, crosses through a two-flop synchronizer, and is edge-detected in the register clock domain. The counters are clocked by the register clock. An 8-bit sample-length value from the engine can also be read.

Registers sit on word-aligned byte addresses:

| Address | Contents | Access |
|---|---|---|
| 0x00 | bit 0 enable; bits 2:1 mode (00 stop, 01 carry fixed data, 10 solo, 11 reserved) | read/write |
| 0x04 + 4*(i-1) | weight i, for i = 1..10, in bits 15:0 | read/write |
| 0x2C | bits 1:0 masking mode; bits 3:2 timeout | read/write |
| 0x30 | input-parse counter | read-only |
| 0x34 | output-build counter | read-only |
| 0x38 | sample length in bits 7:0 | read-only |

Every other address, and every address with bits 1:0 not equal to zero, decodes to no register. Both clock domains use a synchronous, active-high reset.

Top module: `pingpong_csr`

## Requirements
- R1: After reset, the following are all zero: the enable, mode, weight, masking-mode and timeout outputs, both counters, and the read-back of every register.
- R2: A write is accepted in the cycle its enable is high. The write ready flag is high exactly while the write enable is high. The addressed register shows the new value from the next cycle.
- R3: The write error flag is high together with the write enable in these cases: the address is unaligned, the address decodes to no register, or the address is one of the read-only addresses 0x30, 0x34 or 0x38. Such a write changes no register and no output.
- R4: The read valid flag is high exactly in the cycle after a cycle with the read enable high, and is low otherwise. Read data and the read error flag are presented in that same cycle. The read ready flag is always high.
- R5: A read of an unaligned address, or of an address that decodes to no register, sets the read error flag in the valid cycle and returns all-zero data. A read of any mapped address returns no error.
- R6: Address 0x00 holds the enable in bit 0 and the mode in bits 2:1, using the codes 00 stop, 01 carry fixed data and 10 solo. Both fields are driven out, and read back in the same positions with all other bits zero.
- R7: A write of mode code 11 is accepted without error. It updates the enable bit but leaves the mode field unchanged, so the mode output never shows 11.
- R8: Weight i (i = 1..10) sits at address 0x04 + 4*(i-1) in bits 15:0. It is driven on bits [16*i-1 : 16*(i-1)] of the weight bus. Bits 31:16 of a written word are ignored, and writing one weight leaves the others unchanged.
- R9: Address 0x2C holds the masking mode in bits 1:0 and the timeout in bits 3:2. Both are driven out and read back in those positions.
- R10: The input-parse counter at 0x30 rises by exactly one for each single-cycle pulse on the streaming-clock input-done line, provided pulses are more than three register-clock cycles apart.
- R11: The output-build counter at 0x34 rises by exactly one for each output-done pulse, under the same spacing rule. It is independent of the input-parse counter.
- R12: Address 0x38 returns the sample-length input in bits 7:0 with the upper bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_reg | input | 1 | Register-bank clock |
| rst_reg | input | 1 | Synchronous active-high reset, register domain |
| clk_strm | input | 1 | Streaming clock of the completion pulses |
| rst_strm | input | 1 | Synchronous active-high reset, streaming domain |
| wr_addr | input | 32 | Write byte address |
| wr_data | input | 32 | Write data |
| wr_en | input | 1 | Write enable |
| wr_ready | output | 1 | Write accepted |
| wr_err | output | 1 | Write error: unmapped, unaligned or read-only address |
| rd_addr | input | 32 | Read byte address |
| rd_en | input | 1 | Read enable |
| rd_ready | output | 1 | Read channel ready (always high) |
| rd_data | output | 32 | Read data, zero on error |
| rd_valid | output | 1 | Read data valid, one cycle after read enable |
| rd_err | output | 1 | Read error: unmapped or unaligned address |
| eng_enable | output | 1 | Engine enable |
| eng_mode | output | 2 | Engine operating mode |
| weights | output | 160 | Ten 16-bit weights, weight 1 in the low bits |
| mask_mode | output | 2 | Input masking mode |
| odf_timeout | output | 2 | Input wait timeout setting |
| odf_done | input | 1 | Input-parse done pulse, streaming clock |
| adf_done | input | 1 | Output-build done pulse, streaming clock |
| sample_len | input | 8 | Sample-data length status |

## Verification
Timing of each result:

- The write flags are combinational, so they are checked shortly after the write enable rises, within the same register cycle.
- A written field appears on its output port after the next rising edge. The bench therefore samples it at the falling edge that follows that edge.
- Read data, valid and error come from one register stage. The bench samples them one falling edge after the read enable. It then checks that valid has dropped one cycle later.
- A completion pulse reaches its counter only after the streaming-side toggle, two synchronizer flops, the edge-detect flop and the counter flop. The bench spaces pulses by twelve streaming cycles and waits ten register cycles after the last pulse before reading a count.

// File: rtl/pingpong_csr_pkg.sv
package pingpong_csr_pkg;

  // Which register an address selects
  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_WGT,
    SEL_MASK,
    SEL_ODF,
    SEL_ADF,
    SEL_LEN
  } csr_sel_e;

  // Operating mode codes
  localparam logic [1:0] MODE_STOP  = 2'b00;
  localparam logic [1:0] MODE_FIXED = 2'b01;
  localparam logic [1:0] MODE_SOLO  = 2'b10;
  localparam logic [1:0] MODE_RSVD  = 2'b11;

endpackage

// File: rtl/csr_decode.sv
module csr_decode
  import pingpong_csr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NUM_W  = 10,
  localparam int IDX_W  = (NUM_W > 1) ? $clog2(NUM_W) : 1,
  localparam int WORD_W = ADDR_W - 2
) (
  input  logic [ADDR_W-1:0] addr,
  output csr_sel_e          sel,
  output logic [IDX_W-1:0]  idx
);

  // Word offsets of each register, derived from the weight count
  localparam logic [WORD_W-1:0] W_CTRL = '0;
  localparam logic [WORD_W-1:0] W_ONE  = WORD_W'(1);
  localparam logic [WORD_W-1:0] W_WEND = WORD_W'(NUM_W);
  localparam logic [WORD_W-1:0] W_MASK = WORD_W'(NUM_W + 1);
  localparam logic [WORD_W-1:0] W_ODF  = WORD_W'(NUM_W + 2);
  localparam logic [WORD_W-1:0] W_ADF  = WORD_W'(NUM_W + 3);
  localparam logic [WORD_W-1:0] W_LEN  = WORD_W'(NUM_W + 4);

  logic [WORD_W-1:0] word;
  logic [WORD_W-1:0] word_m1;
  logic              aligned;

  assign word    = addr[ADDR_W-1:2];
  assign aligned = (addr[1:0] == 2'b00);
  assign word_m1 = word - W_ONE;

  always_comb begin
    sel = SEL_NONE;
    idx = '0;
    if (aligned) begin
      if (word == W_CTRL) begin
        sel = SEL_CTRL;
      end else if (word <= W_WEND) begin
        sel = SEL_WGT;
        idx = word_m1[IDX_W-1:0];
      end else if (word == W_MASK) begin
        sel = SEL_MASK;
      end else if (word == W_ODF) begin
        sel = SEL_ODF;
      end else if (word == W_ADF) begin
        sel = SEL_ADF;
      end else if (word == W_LEN) begin
        sel = SEL_LEN;
      end
    end
  end

endmodule

// File: rtl/pulse_xfer.sv
module pulse_xfer #(
  parameter int SYNC_STAGES = 2
) (
  input  logic src_clk,
  input  logic src_rst,
  input  logic src_pulse,
  input  logic dst_clk,
  input  logic dst_rst,
  output logic dst_pulse
);

  logic                 src_tgl;
  logic [SYNC_STAGES:0] dst_sh;

  // Each source pulse flips the level that crosses the domain boundary
  always_ff @(posedge src_clk) begin
    if (src_rst) src_tgl <= 1'b0;
    else if (src_pulse) src_tgl <= ~src_tgl;
  end

  // Synchronizer chain plus one extra stage for edge detection
  always_ff @(posedge dst_clk) begin
    if (dst_rst) dst_sh <= '0;
    else dst_sh <= {dst_sh[SYNC_STAGES-1:0], src_tgl};
  end

  assign dst_pulse = dst_sh[SYNC_STAGES] ^ dst_sh[SYNC_STAGES-1];

endmodule

// File: rtl/event_counter.sv
module event_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else if (inc) count <= count + CNT_W'(1);
  end

endmodule

// File: rtl/pingpong_csr.sv
module pingpong_csr
  import pingpong_csr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int NUM_W  = 10,
  parameter int WGT_W  = 16,
  parameter int CNT_W  = 32,
  parameter int LEN_W  = 8
) (
  input  logic                   clk_reg,
  input  logic                   rst_reg,
  input  logic                   clk_strm,
  input  logic                   rst_strm,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic                   wr_en,
  output logic                   wr_ready,
  output logic                   wr_err,
  input  logic [ADDR_W-1:0]      rd_addr,
  input  logic                   rd_en,
  output logic                   rd_ready,
  output logic [DATA_W-1:0]      rd_data,
  output logic                   rd_valid,
  output logic                   rd_err,
  output logic                   eng_enable,
  output logic [1:0]             eng_mode,
  output logic [NUM_W*WGT_W-1:0] weights,
  output logic [1:0]             mask_mode,
  output logic [1:0]             odf_timeout,
  input  logic                   odf_done,
  input  logic                   adf_done,
  input  logic [LEN_W-1:0]       sample_len
);

  localparam int IDX_W  = (NUM_W > 1) ? $clog2(NUM_W) : 1;
  localparam int N_EVT  = 2;

  csr_sel_e         wr_sel;
  csr_sel_e         rd_sel;
  logic [IDX_W-1:0] wr_idx;
  logic [IDX_W-1:0] rd_idx;
  logic             wr_legal;

  logic [WGT_W-1:0] wgt_q [NUM_W];
  logic             en_q;
  logic [1:0]       mode_q;
  logic [1:0]       mask_q;
  logic [1:0]       tmo_q;

  logic [N_EVT-1:0] evt_src;
  logic [N_EVT-1:0] evt_inc;
  logic [CNT_W-1:0] cnt_q [N_EVT];
  logic [CNT_W-1:0] odf_cnt;
  logic [CNT_W-1:0] adf_cnt;

  logic [DATA_W-1:0] rd_word;
  logic              unused_wbits;

  // Address decode, one per channel
  csr_decode #(.ADDR_W(ADDR_W), .NUM_W(NUM_W)) u_wdec (
    .addr (wr_addr),
    .sel  (wr_sel),
    .idx  (wr_idx)
  );

  csr_decode #(.ADDR_W(ADDR_W), .NUM_W(NUM_W)) u_rdec (
    .addr (rd_addr),
    .sel  (rd_sel),
    .idx  (rd_idx)
  );

  // Write channel: accepted at once, error on any non-writable target
  assign wr_legal = (wr_sel == SEL_CTRL) || (wr_sel == SEL_WGT) || (wr_sel == SEL_MASK);
  assign wr_ready = wr_en;
  assign wr_err   = wr_en && !wr_legal;

  always_ff @(posedge clk_reg) begin
    if (rst_reg) begin
      en_q   <= 1'b0;
      mode_q <= MODE_STOP;
      mask_q <= '0;
      tmo_q  <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_CTRL: begin
          en_q <= wr_data[0];
          if (wr_data[2:1] != MODE_RSVD) mode_q <= wr_data[2:1];
        end
        SEL_MASK: begin
          mask_q <= wr_data[1:0];
          tmo_q  <= wr_data[3:2];
        end
        default: ;
      endcase
    end
  end

  // Weight registers and their output slices
  genvar gi;
  generate
    for (gi = 0; gi < NUM_W; gi++) begin : g_wgt
      always_ff @(posedge clk_reg) begin
        if (rst_reg) wgt_q[gi] <= '0;
        else if (wr_en && wr_sel == SEL_WGT && wr_idx == IDX_W'(gi))
          wgt_q[gi] <= wr_data[WGT_W-1:0];
      end
      assign weights[gi*WGT_W +: WGT_W] = wgt_q[gi];
    end
  endgenerate

  assign eng_enable  = en_q;
  assign eng_mode    = mode_q;
  assign mask_mode   = mask_q;
  assign odf_timeout = tmo_q;

  // Completion pulses crossed from the streaming clock and counted
  assign evt_src = {adf_done, odf_done};

  generate
    for (gi = 0; gi < N_EVT; gi++) begin : g_evt
      pulse_xfer #(.SYNC_STAGES(2)) u_xfer (
        .src_clk   (clk_strm),
        .src_rst   (rst_strm),
        .src_pulse (evt_src[gi]),
        .dst_clk   (clk_reg),
        .dst_rst   (rst_reg),
        .dst_pulse (evt_inc[gi])
      );
      event_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk_reg),
        .rst   (rst_reg),
        .inc   (evt_inc[gi]),
        .count (cnt_q[gi])
      );
    end
  endgenerate

  assign odf_cnt = cnt_q[0];
  assign adf_cnt = cnt_q[1];

  // Read channel: one register stage, zero data on error
  always_comb begin
    rd_word = '0;
    case (rd_sel)
      SEL_CTRL: rd_word[2:0]         = {mode_q, en_q};
      SEL_WGT:  rd_word[WGT_W-1:0]   = wgt_q[rd_idx];
      SEL_MASK: rd_word[3:0]         = {tmo_q, mask_q};
      SEL_ODF:  rd_word[CNT_W-1:0]   = odf_cnt;
      SEL_ADF:  rd_word[CNT_W-1:0]   = adf_cnt;
      SEL_LEN:  rd_word[LEN_W-1:0]   = sample_len;
      default:  rd_word              = '0;
    endcase
  end

  always_ff @(posedge clk_reg) begin
    if (rst_reg) begin
      rd_valid <= 1'b0;
      rd_err   <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      rd_err   <= rd_en && (rd_sel == SEL_NONE);
      rd_data  <= rd_en ? rd_word : '0;
    end
  end

  assign rd_ready = 1'b1;

  assign unused_wbits = ^{wr_data[DATA_W-1:WGT_W]};

endmodule

// File: rtl/pingpong_csr_chk.sv
module pingpong_csr_chk #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              wr_err,
  input logic              rd_en,
  input logic              rd_valid,
  input logic              rd_err,
  input logic [DATA_W-1:0] rd_data,
  input logic              eng_enable,
  input logic [1:0]        eng_mode,
  input logic [1:0]        mask_mode,
  input logic [CNT_W-1:0]  odf_count
);

  assert_rd_valid_R4: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  assert_rd_idle_R4: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);

  assert_err_zero_R5: assert property (@(posedge clk) disable iff (rst)
    rd_err |-> (rd_valid && rd_data == '0));

  assert_wr_err_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_err) |=> ($stable(eng_enable) && $stable(eng_mode) && $stable(mask_mode)));

  assert_mode_legal_R7: assert property (@(posedge clk) disable iff (rst)
    eng_mode != 2'b11);

  assert_cnt_step_R10: assert property (@(posedge clk) disable iff (rst)
    (odf_count == $past(odf_count)) || (odf_count == $past(odf_count) + CNT_W'(1)));

endmodule

bind pingpong_csr pingpong_csr_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk_reg),
  .rst        (rst_reg),
  .wr_en      (wr_en),
  .wr_err     (wr_err),
  .rd_en      (rd_en),
  .rd_valid   (rd_valid),
  .rd_err     (rd_err),
  .rd_data    (rd_data),
  .eng_enable (eng_enable),
  .eng_mode   (eng_mode),
  .mask_mode  (mask_mode),
  .odf_count  (odf_cnt)
);

// File: tb/pingpong_csr_bench.sv
module pingpong_csr_bench;

  logic         clk_reg = 1'b0;
  logic         clk_strm = 1'b0;
  logic         rst_reg = 1'b1;
  logic         rst_strm = 1'b1;
  logic [31:0]  wr_addr = '0;
  logic [31:0]  wr_data = '0;
  logic         wr_en = 1'b0;
  logic         wr_ready, wr_err;
  logic [31:0]  rd_addr = '0;
  logic         rd_en = 1'b0;
  logic         rd_ready;
  logic [31:0]  rd_data;
  logic         rd_valid, rd_err;
  logic         eng_enable;
  logic [1:0]   eng_mode;
  logic [159:0] weights;
  logic [1:0]   mask_mode, odf_timeout;
  logic         odf_done = 1'b0;
  logic         adf_done = 1'b0;
  logic [7:0]   sample_len = '0;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk_reg = ~clk_reg;   // 50 MHz
  always #3.5 clk_strm = ~clk_strm;

  pingpong_csr u_pingpong_csr (
    .clk_reg, .rst_reg, .clk_strm, .rst_strm,
    .wr_addr, .wr_data, .wr_en, .wr_ready, .wr_err,
    .rd_addr, .rd_en, .rd_ready, .rd_data, .rd_valid, .rd_err,
    .eng_enable, .eng_mode, .weights, .mask_mode, .odf_timeout,
    .odf_done, .adf_done, .sample_len
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [31:0] a, input logic [31:0] d, input bit exp_err, input string req);
    @(negedge clk_reg);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    #1;
    chk(wr_ready === 1'b1, "R2 ready", {63'd0, wr_ready}, 64'd1);
    chk(wr_err === exp_err, req, {63'd0, wr_err}, {63'd0, exp_err});
    @(negedge clk_reg);
    wr_en = 1'b0;
    #1;
    chk(wr_ready === 1'b0 && wr_err === 1'b0, "R2 idle", {62'd0, wr_ready, wr_err}, 64'd0);
  endtask

  task automatic do_rd(input logic [31:0] a, input bit exp_err, input logic [31:0] exp_d, input string req);
    @(negedge clk_reg);
    rd_addr = a; rd_en = 1'b1;
    @(negedge clk_reg);
    rd_en = 1'b0;
    chk(rd_valid === 1'b1 && rd_ready === 1'b1, "R4 valid", {62'd0, rd_valid, rd_ready}, 64'd3);
    chk(rd_err === exp_err, "R5 err", {63'd0, rd_err}, {63'd0, exp_err});
    chk(rd_data === exp_d, req, {32'd0, rd_data}, {32'd0, exp_d});
    @(negedge clk_reg);
    chk(rd_valid === 1'b0, "R4 drop", {63'd0, rd_valid}, 64'd0);
  endtask

  task automatic pulse_odf();
    @(negedge clk_strm); odf_done = 1'b1;
    @(negedge clk_strm); odf_done = 1'b0;
    repeat (12) @(negedge clk_strm);
  endtask

  task automatic pulse_adf();
    @(negedge clk_strm); adf_done = 1'b1;
    @(negedge clk_strm); adf_done = 1'b0;
    repeat (12) @(negedge clk_strm);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_reg);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual running expected done");
    report();
  end

  initial begin
    logic       exp_en;
    logic [1:0] exp_mode;
    logic [15:0] wv [10];
    repeat (5) @(negedge clk_reg);
    rst_reg = 1'b0; rst_strm = 1'b0;
    @(negedge clk_reg);

    // R1: reset state
    chk(eng_enable === 1'b0 && eng_mode === 2'b00, "R1 ctrl", {62'd0, eng_mode}, 64'd0);
    chk(weights === '0, "R1 weights", weights[63:0], 64'd0);
    chk(mask_mode === 2'b00 && odf_timeout === 2'b00, "R1 mask", {60'd0, odf_timeout, mask_mode}, 64'd0);
    for (int a = 0; a <= 'h38; a += 4) do_rd(a, 1'b0, 32'd0, "R1 readback");

    // R6 R7: sweep of the control word
    exp_en = 1'b0; exp_mode = 2'b00;
    for (int v = 0; v < 8; v++) begin
      logic [2:0] vb;
      vb = 3'(v);
      do_wr(32'h00, {29'h1FFFFFFF, vb}, 1'b0, "R7 no error");
      exp_en = vb[0];
      if (vb[2:1] != 2'b11) exp_mode = vb[2:1];
      chk(eng_enable === exp_en && eng_mode === exp_mode, "R6 R7 ctrl out",
          {61'd0, eng_mode, eng_enable}, {61'd0, exp_mode, exp_en});
      do_rd(32'h00, 1'b0, {29'd0, exp_mode, exp_en}, "R6 ctrl read");
    end

    // R8: every weight, upper write bits ignored
    for (int i = 0; i < 10; i++) begin
      wv[i] = 16'(16'h1111 * (i + 1) + 16'(i * 7));
      do_wr(32'(4 + 4 * i), {16'hDEAD, wv[i]}, 1'b0, "R8 wr");
      chk(weights[16*i +: 16] === wv[i], "R8 slice", {48'd0, weights[16*i +: 16]}, {48'd0, wv[i]});
    end
    for (int i = 0; i < 10; i++) begin
      chk(weights[16*i +: 16] === wv[i], "R8 retained", {48'd0, weights[16*i +: 16]}, {48'd0, wv[i]});
      do_rd(32'(4 + 4 * i), 1'b0, {16'd0, wv[i]}, "R8 read");
    end

    // R9: masking mode and timeout sweep
    for (int v = 0; v < 16; v++) begin
      logic [3:0] vb;
      vb = 4'(v);
      do_wr(32'h2C, {28'hABCDEF0, vb}, 1'b0, "R9 wr");
      chk(mask_mode === vb[1:0] && odf_timeout === vb[3:2], "R9 out",
          {60'd0, odf_timeout, mask_mode}, {60'd0, vb});
      do_rd(32'h2C, 1'b0, {28'd0, vb}, "R9 read");
    end

    // R3: error writes leave state alone
    do_wr(32'h00, 32'h3, 1'b0, "R2 ctrl");   // enable 1, mode 01
    do_wr(32'h01, 32'h4, 1'b1, "R3 unaligned");
    do_wr(32'h30, 32'hFF, 1'b1, "R3 odf ro");
    do_wr(32'h34, 32'hFF, 1'b1, "R3 adf ro");
    do_wr(32'h38, 32'hFF, 1'b1, "R3 len ro");
    do_wr(32'h3C, 32'h4, 1'b1, "R3 unmapped");
    do_wr(32'h8000_0000, 32'h4, 1'b1, "R3 high addr");
    chk(eng_enable === 1'b1 && eng_mode === 2'b01, "R3 ctrl held", {61'd0, eng_mode, eng_enable}, 64'd3);
    do_rd(32'h00, 1'b0, 32'h3, "R3 ctrl held read");
    do_rd(32'h30, 1'b0, 32'h0, "R3 counter held");
    do_rd(32'h04, 1'b0, {16'd0, wv[0]}, "R3 weight held");

    // R5: read errors
    do_rd(32'h3C, 1'b1, 32'h0, "R5 unmapped");
    do_rd(32'h06, 1'b1, 32'h0, "R5 unaligned");
    do_rd(32'h8000_0004, 1'b1, 32'h0, "R5 high addr");

    // R12: sample length
    sample_len = 8'hC3;
    do_rd(32'h38, 1'b0, 32'hC3, "R12 len");
    sample_len = 8'h5A;
    do_rd(32'h38, 1'b0, 32'h5A, "R12 len");

    // R10 R11: counted completion pulses
    for (int k = 0; k < 5; k++) pulse_odf();
    repeat (10) @(negedge clk_reg);
    do_rd(32'h30, 1'b0, 32'd5, "R10 odf count");
    do_rd(32'h34, 1'b0, 32'd0, "R11 adf idle");
    for (int k = 0; k < 9; k++) pulse_adf();
    repeat (10) @(negedge clk_reg);
    do_rd(32'h34, 1'b0, 32'd9, "R11 adf count");
    do_rd(32'h30, 1'b0, 32'd5, "R10 odf unchanged");
    for (int k = 0; k < 3; k++) begin pulse_odf(); pulse_adf(); end
    repeat (10) @(negedge clk_reg);
    do_rd(32'h30, 1'b0, 32'd8, "R10 odf mixed");
    do_rd(32'h34, 1'b0, 32'd12, "R11 adf mixed");

    report();
  end

endmodule